// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns characters into an asynchronous serial bit stream on a single output line. A character is written into a one-entry holding register. From there it moves into a frame shifter that sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. Control inputs set the character length, parity on or off, even or odd parity, and the stop-bit count. These inputs are captured when each frame begins, so a change made in the middle of a frame applies only from the next frame on.

A transmit-enable input switches the transmitter on. When it drops, the transmitter keeps running until the frame on the line and any character still waiting in the holding register have both gone out, and only then does it stop. Two status outputs serve the producer of characters. Holding-empty shows that a new character may be written. A one-cycle completion pulse marks the moment the line has fully drained. Each bit lasts a number of clock cycles set by a divider parameter.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, holding-empty is high and the completion pulse is low.
- R2: A frame begins with one low start bit, the line is high whenever no frame is being sent, and data bits go out least significant bit first.
- R3: The size code sets the number of data bits: code 0 gives 8, code 1 gives 9 (taken from data bit 8), codes 5, 6 and 7 give that many bits, and the reserved codes 2, 3 and 4 are sent as 8 bits.
- R4: With parity enabled, a parity bit follows the data bits. Parity mode 0 makes the count of ones over the data and parity bits even, and mode 1 makes it odd. With parity disabled, no parity bit is sent.
- R5: Stop-bit mode 0 sends one high stop bit and mode 1 sends two.
- R6: Every bit of a frame, start and stop bits included, lasts exactly BAUD_DIV clock cycles.
- R7: A write is taken only while holding-empty is high, transmit-enable is high, and transmit-enable has been high for at least one earlier cycle. Holding-empty is low from the cycle after an accepted write until the character moves into the shifter.
- R8: A write made while transmit-enable is low is ignored: holding-empty stays high and no frame is sent.
- R9: When transmit-enable falls, the frame in progress and the character pending in the holding register are both sent in full before the transmitter stops.
- R10: The completion pulse is high for exactly the one cycle after the last stop bit ends, and only if no further character is waiting. Between back-to-back frames it stays low.
- R11: The format inputs are captured at the start of each frame. Changing them while a frame is being sent does not alter that frame.
- R12: A character waiting in the holding register when a frame ends starts its start bit in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send (bit 8 used only in 9-bit mode) |
| size_code | input | 3 | Character size code |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity mode, 0 even, 1 odd |
| two_stop | input | 1 | Stop-bit mode, 0 one stop bit, 1 two stop bits |
| txd | output | 1 | Serial line output |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmit complete pulse |

## Verification
A wrong bit counter or wrong shift content shows within one frame as a sample in the middle of a bit that does not match, or as a completion pulse that comes early or late against a frame length counted in BAUD_DIV units. A fault in the holding register or the enable logic shows as a frame that never appears or appears without being wanted, as a gap before a queued start bit, or as holding-empty staying high after a write. These faults show no later than the end of the next frame. If the format inputs are captured at the wrong time, the frame in which the inputs change shows mismatching bits while that frame is still on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W    = 9;
    localparam int MAX_FRAME = 1 + DATA_W + 1 + 2;
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);

    typedef struct packed {
        logic [2:0] size_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } fmt_t;

    // Number of data bits for a size code; reserved codes fall back to 8.
    function automatic logic [LEN_W-1:0] data_bits(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'd1:    n = LEN_W'(9);
            3'd5:    n = LEN_W'(5);
            3'd6:    n = LEN_W'(6);
            3'd7:    n = LEN_W'(7);
            default: n = LEN_W'(8);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic load,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_state_t;

    baud_state_t st_d, st_q;

    assign tick = busy && (st_q.cnt == CNT_W'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (!busy || load || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_state_t;

    hold_state_t st_d, st_q;

    assign full = st_q.full;
    assign data = st_q.data;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (wr) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  fmt_t              load_fmt,
    input  logic              tick,
    output logic              busy,
    output logic              txd,
    output logic              frame_end
);
    typedef struct packed {
        logic                 busy;
        logic                 txd;
        logic [MAX_FRAME-1:0] sh;
        logic [LEN_W-1:0]     left;
    } shift_state_t;

    shift_state_t st_d, st_q;

    logic [MAX_FRAME-1:0] frame;
    logic [LEN_W-1:0]     frame_len;
    logic [LEN_W-1:0]     nbits;
    logic                 par_bit;

    assign busy      = st_q.busy;
    assign txd       = st_q.txd;
    assign frame_end = st_q.busy && tick && (st_q.left == LEN_W'(1));

    // Assemble the whole frame: stop bits come from the all-ones fill.
    always_comb begin
        nbits   = data_bits(load_fmt.size_code);
        frame   = '1;
        frame[0] = 1'b0;
        par_bit = load_fmt.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) begin
                frame[i + 1] = load_data[i];
                par_bit      = par_bit ^ load_data[i];
            end
        end
        if (load_fmt.par_en) begin
            frame[nbits + LEN_W'(1)] = par_bit;
        end
        frame_len = LEN_W'(2) + nbits + LEN_W'(load_fmt.par_en) + LEN_W'(load_fmt.two_stop);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.busy && tick) begin
            st_d.sh   = {1'b1, st_q.sh[MAX_FRAME-1:1]};
            st_d.txd  = st_q.sh[1];
            st_d.left = st_q.left - LEN_W'(1);
            if (frame_end) begin
                st_d.busy = 1'b0;
                st_d.txd  = 1'b1;
            end
        end
        if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = frame;
            st_d.txd  = frame[0];
            st_d.left = frame_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.txd  <= 1'b1;
            st_q.sh   <= '1;
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic wr_valid,
    input  logic hold_full,
    input  logic busy,
    input  logic frame_end,
    output logic accept,
    output logic load,
    output logic txc
);
    typedef struct packed {
        logic run;
        logic txc;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    assign accept = wr_valid && !hold_full && tx_en && st_q.run;
    assign load   = st_q.run && hold_full && (!busy || frame_end);
    assign txc    = st_q.txc;

    always_comb begin
        st_d = st_q;
        // Stay running after enable drops until both stages are drained.
        st_d.run = tx_en || (st_q.run && (hold_full || busy));
        st_d.txc = frame_end && !hold_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int BAUD_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        size_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              txd,
    output logic              dre,
    output logic              txc
);
    fmt_t              fmt;
    logic              accept;
    logic              load;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              tick;
    logic              frame_end;

    assign fmt = '{size_code: size_code, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign dre = !hold_full;

    uart_tx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .wr_valid  (wr_valid),
        .hold_full (hold_full),
        .busy      (busy),
        .frame_end (frame_end),
        .accept    (accept),
        .load      (load),
        .txc       (txc)
    );

    uart_tx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (accept),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_baud #(.DIV(BAUD_DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .load  (load),
        .tick  (tick)
    );

    uart_tx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (hold_data),
        .load_fmt  (fmt),
        .tick      (tick),
        .busy      (busy),
        .txd       (txd),
        .frame_end (frame_end)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic dre,
    input logic txc,
    input logic txd,
    input logic busy,
    input logic accept
);
    AST_TXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        txc |=> !txc); // R10

    AST_TXC_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        txc |-> (!busy && txd)); // R10

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R2

    AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !dre); // R7

    AST_DISABLED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && dre) |=> dre); // R8
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .dre    (dre),
    .txc    (txc),
    .txd    (txd),
    .busy   (busy),
    .accept (accept)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int DRAIN      = 14 * DIV + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic [2:0] size_code = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd, dre, txc;

    int checks = 0;
    int fails  = 0;
    logic [8:0] expq [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;
    bit mid_test = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_frame_tx #(.BAUD_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .size_code(size_code), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop), .txd(txd), .dre(dre), .txc(txc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected frame from the requirements: start, data LSB first, parity, stops.
    function automatic void build(input logic [8:0] d, input logic [2:0] sz,
                                  input logic pe, input logic po, input logic ts,
                                  output logic [12:0] bits, output int len, output int nd);
        logic p;
        case (sz)
            3'd1: nd = 9;
            3'd5, 3'd6, 3'd7: nd = int'(sz);
            default: nd = 8;
        endcase
        bits = '1;
        bits[0] = 1'b0;
        p = po;
        for (int k = 0; k < nd; k++) begin
            bits[1 + k] = d[k];
            p = p ^ d[k];
        end
        len = 1 + nd;
        if (pe) begin
            bits[len] = p;
            len++;
        end
        len += ts ? 2 : 1;
    endfunction

    // Line monitor
    initial begin
        bit pend = 1'b0;
        bit pend_val = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (pend) begin
                chk(txc == pend_val, "R10", txc, pend_val);
                if (!pend_val) chk(txd == 1'b0, "R12", txd, 0);
                pend = 1'b0;
            end
            if (txd == 1'b0) begin
                logic [12:0] bits;
                int len, nd;
                logic [8:0] d;
                logic [2:0] f_sz;
                logic f_pe, f_po, f_ts;
                f_sz = size_code; f_pe = par_en; f_po = par_odd; f_ts = two_stop;
                if (rd_ptr == wr_ptr) begin
                    chk(1'b0, "R8", 1, 0);
                    d = '0;
                end else begin
                    d = expq[rd_ptr % 256];
                    rd_ptr++;
                end
                build(d, f_sz, f_pe, f_po, f_ts, bits, len, nd);
                for (int n = 0; n < len * DIV; n++) begin
                    if (n > 0) @(negedge clk);
                    if (n % DIV == DIV / 2) begin
                        int b;
                        string tag;
                        b = n / DIV;
                        if (mid_test && b > 0) tag = "R11";
                        else if (b == 0) tag = "R2";
                        else if (b <= nd) tag = "R3";
                        else if (f_pe && b == nd + 1) tag = "R4";
                        else tag = "R5";
                        chk(txd == bits[b], tag, txd, bits[b]);
                    end
                    if (n == len * DIV - 1) begin
                        chk(txd == 1'b1, "R6", txd, 1);
                        chk(txc == 1'b0, "R10", txc, 0);
                        pend = 1'b1;
                        pend_val = (rd_ptr == wr_ptr);
                    end
                end
            end
        end
    end

    task automatic send(input logic [8:0] d);
        do @(negedge clk); while (!dre);
        @(posedge clk); #1;
        wr_valid = 1'b1;
        wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        @(negedge clk);
        chk(dre == 1'b0, "R7", dre, 0);
        expq[wr_ptr % 256] = d;
        wr_ptr++;
    endtask

    task automatic drain();
        while (rd_ptr != wr_ptr) @(negedge clk);
        repeat (DRAIN) @(negedge clk);
    endtask

    task automatic set_fmt(input logic [2:0] sz, input logic pe, input logic po, input logic ts);
        @(posedge clk); #1;
        size_code = sz; par_en = pe; par_odd = po; two_stop = ts;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", txd, 1);
        chk(dre == 1'b1, "R1", dre, 1);
        chk(txc == 1'b0, "R1", txc, 0);

        @(posedge clk); #1 tx_en = 1'b1;
        repeat (2) @(posedge clk);

        // Directed formats
        set_fmt(3'd0, 1'b0, 1'b0, 1'b0); send(9'h0A5); drain();
        set_fmt(3'd1, 1'b1, 1'b0, 1'b1); send(9'h1C3); drain();
        set_fmt(3'd5, 1'b1, 1'b1, 1'b0); send(9'h016); drain();
        set_fmt(3'd3, 1'b1, 1'b1, 1'b1); send(9'h17E); drain();
        set_fmt(3'd7, 1'b0, 1'b0, 1'b1); send(9'h055); send(9'h02A); send(9'h07F); drain();

        // Format change in the middle of a frame
        set_fmt(3'd6, 1'b1, 1'b0, 1'b0);
        mid_test = 1'b1;
        send(9'h02D);
        do @(negedge clk); while (txd);
        repeat (2 * DIV) @(posedge clk);
        #1 size_code = 3'd1; par_en = 1'b0; par_odd = 1'b1; two_stop = 1'b1;
        drain();
        mid_test = 1'b0;
        chk(rd_ptr == wr_ptr, "R11", rd_ptr, wr_ptr);

        // Disable with one frame active and one pending
        set_fmt(3'd0, 1'b1, 1'b0, 1'b0);
        send(9'h0F0);
        send(9'h00F);
        @(posedge clk); #1 tx_en = 1'b0;
        drain();
        chk(rd_ptr == wr_ptr, "R9", wr_ptr - rd_ptr, 0);

        // Write while disabled
        @(posedge clk); #1 wr_valid = 1'b1; wr_data = 9'h0AA;
        @(posedge clk); #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(dre == 1'b1, "R8", dre, 1);
        repeat (2 * DRAIN) @(negedge clk);
        chk(txd == 1'b1, "R8", txd, 1);
        chk(dre == 1'b1, "R8", dre, 1);

        @(posedge clk); #1 tx_en = 1'b1;
        repeat (2) @(posedge clk);

        // Random rounds
        for (int r = 0; r < 16; r++) begin
            int burst;
            set_fmt(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom));
            burst = $urandom_range(1, 4);
            for (int k = 0; k < burst; k++) send(9'($urandom));
            drain();
        end

        @(posedge clk); #1 tx_en = 1'b0;
        drain();
        chk(rd_ptr == wr_ptr, "R9", wr_ptr - rd_ptr, 0);
        chk(txd == 1'b1, "R2", txd, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule